// File: doc/BRIEF.md
# Vectored Grouped Interrupt Controller

This block gathers interrupt requests from timers, other peripherals and external pins. Each source is registered in its own group. A group has exactly one vector, so the controller hands the CPU the winning group number directly and software never has to sort out which source fired. Every group belongs to a priority class, and the class carries a programmable level. The CPU supplies its current mask level. A request is raised only when the best pending group outranks that mask.

Requests are latched per group and gated by a per-group enable. Groups 1 to 3 are system groups, and their enable bit has no effect. Six external pins pass through a synchronizer and then an edge or level detector. A mode register selects the detector for each pin. The CPU takes a request with a one-cycle acknowledge. The acknowledge clears the granted group and freezes the reported number for one cycle, so the handover is clean.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, cpuReq is 0. All enable bits and pending bits read 0, every class level reads 7 and the pin mode register reads 0.
- R2: An internal request input that is high at a clock edge sets that group's pending bit. Group g appears at address 0x04 + g/32, bit g%32. The bit stays set until it is cleared by writing a 1 to that bit or by an acknowledge of that group.
- R3: A group whose enable bit is 0 never requests the CPU but still records pending. The enable bit is at address 0x00 + g/32, bit g%32. For groups 1 to 3 the enable bit is ignored.
- R4: Group g belongs to class g/3. Class c has its level in bits [2:0] of address 0x20 + c, and level 0 ranks highest. A request is raised only when the winning level is strictly below cpuMask. Level 7 never requests.
- R5: Among enabled pending groups, the lowest level value wins. A tie goes to the lowest group number.
- R6: When an internal request is sampled at clock edge n, cpuReq and cpuGroup show it after edge n+1.
- R7: cpuAck high while cpuReq is high is taken at that edge. In the next cycle cpuReq is 0 and cpuGroup is unchanged, and the pending bit of the granted group is cleared.
- R8: Pin k drives group 30+k, and irqIn bits 30 to 35 are ignored. The pin mode field is at address 0x08, bits [2k+1:2k]: 0 rising, 1 falling, 2 either edge, 3 active-low level.
- R9: A qualifying pin edge driven before clock edge n makes cpuReq high after edge n+3. In level mode the pending bit follows the inverted pin, and neither write-clear nor acknowledge changes it.
- R10: Enable words read back only the implemented group bits (address 0x01 reads 0xF after writing all ones), and the mode register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 6 | Register address |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| irqIn | input | 36 | Raw internal request per group |
| extPin | input | 6 | Asynchronous external interrupt pins |
| cpuMask | input | 3 | CPU current mask level |
| cpuAck | input | 1 | CPU acknowledge of the presented group |
| cpuReq | output | 1 | Interrupt request to the CPU |
| cpuGroup | output | 6 | Number of the winning group |

## Verification
The hardest situation to reach is a queue of several pending groups draining in strict priority order. That order includes a tie inside one class, and every step passes through the one-cycle acknowledge gap. To set it up, the bench pulses four request lines in the same cycle while acknowledges are held off. It then loads the scoreboard with the expected grant order and releases the acknowledging monitor. The external pin paths are the next hardest. Reaching them needs exact cycle counting through the synchronizer, and a level-mode pin has to be shown resisting both clear mechanisms.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int LEVEL_W = 3;
  localparam int MODE_W  = 2;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    LEVEL_LOW = 2'd3
  } extMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ackTake;
  } ctlStrobe_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath import vic_pkg::*; #(
  parameter int NUM_GROUPS  = 36,
  parameter int NUM_CLASSES = 12,
  parameter int NUM_EXT     = 6,
  parameter int EXT_BASE    = 30,
  parameter int SYS_FIRST   = 1,
  parameter int SYS_LAST    = 3,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int GIDX_W      = 6,
  parameter int ADDR_EN     = 0,
  parameter int ADDR_PEND   = 4,
  parameter int ADDR_MODE   = 8,
  parameter int ADDR_LVL    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWr,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             regRdata,
  input  logic [NUM_GROUPS-1:0]         irqIn,
  input  logic [NUM_EXT-1:0]            extPin,
  input  ctlStrobe_t                    strobe,
  input  logic [GIDX_W-1:0]             curGroup,
  output logic [NUM_GROUPS-1:0]         activeVec,
  output logic [NUM_GROUPS*LEVEL_W-1:0] groupLevel
);
  localparam int GPC  = NUM_GROUPS / NUM_CLASSES;
  localparam int ENW  = (NUM_GROUPS + DATA_W - 1) / DATA_W;
  localparam int PADW = ENW * DATA_W;

  logic [NUM_EXT-1:0]        syncA, syncB, prevQ, edgeHit;
  logic [MODE_W*NUM_EXT-1:0] modeQ;
  logic [LEVEL_W-1:0]        classLvl [NUM_CLASSES];
  logic [NUM_GROUPS-1:0]     enableQ, pendQ;
  logic [PADW-1:0]           enPad, pendPad;
  logic                      wrMode;

  assign wrMode = regWr && (regAddr == ADDR_W'(ADDR_MODE));

  // two-flop synchronizer plus history; pins idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '1;
      prevQ <= '1;
    end else begin
      syncA <= extPin;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  always_comb begin
    for (int e = 0; e < NUM_EXT; e++) begin
      case (extMode_e'(modeQ[e*MODE_W +: MODE_W]))
        EDGE_RISE: edgeHit[e] = syncB[e] & ~prevQ[e];
        EDGE_FALL: edgeHit[e] = ~syncB[e] & prevQ[e];
        EDGE_BOTH: edgeHit[e] = syncB[e] ^ prevQ[e];
        default:   edgeHit[e] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= '0;
    else if (wrMode) modeQ <= regWdata[MODE_W*NUM_EXT-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CLASSES; c++) classLvl[c] <= '1;
    end else begin
      for (int c = 0; c < NUM_CLASSES; c++)
        if (regWr && regAddr == ADDR_W'(ADDR_LVL + c)) classLvl[c] <= regWdata[LEVEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableQ <= '0;
    else begin
      for (int g = 0; g < NUM_GROUPS; g++)
        if (regWr && regAddr == ADDR_W'(ADDR_EN + g / DATA_W)) enableQ[g] <= regWdata[g % DATA_W];
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam bit IS_SYS = (g >= SYS_FIRST) && (g <= SYS_LAST);
    logic setEv, clrEv, lvlMode, lvlVal, pendBit;

    assign clrEv = (regWr && regAddr == ADDR_W'(ADDR_PEND + g / DATA_W) && regWdata[g % DATA_W])
                || (strobe.ackTake && curGroup == GIDX_W'(g));

    if (g >= EXT_BASE && g < EXT_BASE + NUM_EXT) begin : g_ext
      localparam int E = g - EXT_BASE;
      logic unusedIrq;
      assign unusedIrq = irqIn[g];
      assign setEv   = edgeHit[E];
      assign lvlMode = (modeQ[E*MODE_W +: MODE_W] == LEVEL_LOW);
      assign lvlVal  = ~syncB[E];
    end else begin : g_int
      assign setEv   = irqIn[g];
      assign lvlMode = 1'b0;
      assign lvlVal  = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        pendBit <= 1'b0;
      else if (lvlMode) pendBit <= lvlVal;
      else if (setEv)   pendBit <= 1'b1;
      else if (clrEv)   pendBit <= 1'b0;
    end

    assign pendQ[g]     = pendBit;
    assign activeVec[g] = pendBit & (enableQ[g] | IS_SYS);
    assign groupLevel[g*LEVEL_W +: LEVEL_W] = classLvl[g / GPC];
  end

  assign enPad   = PADW'(enableQ);
  assign pendPad = PADW'(pendQ);

  always_comb begin
    regRdata = '0;
    for (int w = 0; w < ENW; w++) begin
      if (regAddr == ADDR_W'(ADDR_EN + w))   regRdata = enPad[w*DATA_W +: DATA_W];
      if (regAddr == ADDR_W'(ADDR_PEND + w)) regRdata = pendPad[w*DATA_W +: DATA_W];
    end
    if (regAddr == ADDR_W'(ADDR_MODE)) regRdata = DATA_W'(modeQ);
    for (int c = 0; c < NUM_CLASSES; c++)
      if (regAddr == ADDR_W'(ADDR_LVL + c)) regRdata = DATA_W'(classLvl[c]);
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter import vic_pkg::*; #(
  parameter int NUM_GROUPS = 36,
  parameter int GIDX_W     = 6
) (
  input  logic [NUM_GROUPS-1:0]         activeVec,
  input  logic [NUM_GROUPS*LEVEL_W-1:0] groupLevel,
  output logic                          winValid,
  output logic [GIDX_W-1:0]             winGroup,
  output logic [LEVEL_W-1:0]            winLevel
);
  // scan downward so an equal level at a lower index replaces the holder
  always_comb begin
    winValid = 1'b0;
    winGroup = '0;
    winLevel = '1;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (activeVec[g] && groupLevel[g*LEVEL_W +: LEVEL_W] <= winLevel) begin
        winValid = 1'b1;
        winGroup = GIDX_W'(g);
        winLevel = groupLevel[g*LEVEL_W +: LEVEL_W];
      end
    end
  end
endmodule

// File: rtl/vic_control.sv
module vic_control import vic_pkg::*; #(
  parameter int GIDX_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               winValid,
  input  logic [GIDX_W-1:0]  winGroup,
  input  logic [LEVEL_W-1:0] winLevel,
  input  logic [LEVEL_W-1:0] cpuMask,
  input  logic               cpuAck,
  output logic               cpuReq,
  output logic [GIDX_W-1:0]  cpuGroup,
  output ctlStrobe_t         strobe
);
  logic              reqQ;
  logic [GIDX_W-1:0] groupQ;

  assign strobe.ackTake = reqQ && cpuAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ   <= 1'b0;
      groupQ <= '0;
    end else if (strobe.ackTake) begin
      reqQ   <= 1'b0;              // group number frozen for this cycle
    end else begin
      reqQ <= winValid && (winLevel < cpuMask);
      if (winValid) groupQ <= winGroup;
    end
  end

  assign cpuReq   = reqQ;
  assign cpuGroup = groupQ;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl import vic_pkg::*; #(
  parameter int NUM_GROUPS  = 36,
  parameter int NUM_CLASSES = 12,
  parameter int NUM_EXT     = 6,
  parameter int EXT_BASE    = 30,
  parameter int SYS_FIRST   = 1,
  parameter int SYS_LAST    = 3,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWr,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             regRdata,
  input  logic [NUM_GROUPS-1:0]         irqIn,
  input  logic [NUM_EXT-1:0]            extPin,
  input  logic [LEVEL_W-1:0]            cpuMask,
  input  logic                          cpuAck,
  output logic                          cpuReq,
  output logic [$clog2(NUM_GROUPS)-1:0] cpuGroup
);
  localparam int GIDX_W = $clog2(NUM_GROUPS);

  ctlStrobe_t                    strobe;
  logic [NUM_GROUPS-1:0]         activeVec;
  logic [NUM_GROUPS*LEVEL_W-1:0] groupLevel;
  logic                          winValid;
  logic [GIDX_W-1:0]             winGroup;
  logic [LEVEL_W-1:0]            winLevel;

  vic_datapath #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_CLASSES(NUM_CLASSES), .NUM_EXT(NUM_EXT),
    .EXT_BASE(EXT_BASE), .SYS_FIRST(SYS_FIRST), .SYS_LAST(SYS_LAST),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GIDX_W(GIDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irqIn(irqIn), .extPin(extPin), .strobe(strobe),
    .curGroup(cpuGroup), .activeVec(activeVec), .groupLevel(groupLevel)
  );

  vic_arbiter #(.NUM_GROUPS(NUM_GROUPS), .GIDX_W(GIDX_W)) u_arb (
    .activeVec(activeVec), .groupLevel(groupLevel),
    .winValid(winValid), .winGroup(winGroup), .winLevel(winLevel)
  );

  vic_control #(.GIDX_W(GIDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winGroup(winGroup), .winLevel(winLevel),
    .cpuMask(cpuMask), .cpuAck(cpuAck), .cpuReq(cpuReq), .cpuGroup(cpuGroup), .strobe(strobe)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker import vic_pkg::*; #(
  parameter int NUM_GROUPS = 36,
  parameter int GIDX_W     = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [LEVEL_W-1:0]    cpuMask,
  input logic                  cpuAck,
  input logic                  cpuReq,
  input logic [GIDX_W-1:0]     cpuGroup,
  input logic [NUM_GROUPS-1:0] activeVec
);
  logic [NUM_GROUPS-1:0] activePast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activePast <= '0;
    else       activePast <= activeVec;
  end

  p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuAck) |=> (!cpuReq && $stable(cpuGroup)));

  p_mask_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuMask) == '0) |-> !cpuReq);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(activeVec) == '0) |-> !cpuReq);

  p_req_from_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> activePast[cpuGroup]);

  p_group_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> ({1'b0, cpuGroup} < (GIDX_W + 1)'(NUM_GROUPS)));
endmodule

bind vec_irq_ctrl vic_checker #(.NUM_GROUPS(NUM_GROUPS), .GIDX_W(GIDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuMask(cpuMask), .cpuAck(cpuAck),
  .cpuReq(cpuReq), .cpuGroup(cpuGroup), .activeVec(activeVec)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  logic        clk = 0;
  logic        rstN = 0;
  logic [5:0]  regAddr = '0;
  logic        regWr = 0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [35:0] irqIn = '0;
  logic [5:0]  extPin = '1;
  logic [2:0]  cpuMask = '0;
  logic        cpuAck;
  logic        cpuReq;
  logic [5:0]  cpuGroup;

  int  nCmp = 0, nBad = 0;
  int  expQ[$];
  bit  autoAck = 0;
  bit  finished = 0;
  int  lastAck = 0;

  vec_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irqIn(irqIn), .extPin(extPin), .cpuMask(cpuMask),
    .cpuAck(cpuAck), .cpuReq(cpuReq), .cpuGroup(cpuGroup)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); regAddr = 6'(a); regWdata = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); regAddr = 6'(a); #1; d = regRdata;
  endtask

  task automatic pulse(input logic [35:0] bits);
    @(negedge clk); irqIn = bits;
    @(negedge clk); irqIn = '0;
  endtask

  task automatic expectGrp(input int g);
    expQ.push_back(g);
  endtask

  task automatic drain();
    int n = 0;
    autoAck = 1;
    while (expQ.size() != 0 && n < 200) begin @(negedge clk); n++; end
    if (expQ.size() != 0) begin
      chk(0, "R5", "grants missing", expQ.size(), 0);
      expQ.delete();
    end
    repeat (4) @(negedge clk);
    autoAck = 0;
  endtask

  task automatic quiet(input string tag, input string what);
    repeat (6) @(negedge clk);
    chk(cpuReq == 0, tag, what, cpuReq, 0);
  endtask

  // monitor: pops the scoreboard and acknowledges
  initial begin
    int e;
    cpuAck = 0;
    forever begin
      @(negedge clk);
      if (cpuAck) begin
        cpuAck = 0;
        chk(cpuReq == 0, "R7", "request dropped after ack", cpuReq, 0);
        chk(cpuGroup == 6'(lastAck), "R7", "group held after ack", cpuGroup, lastAck);
      end else if (autoAck && rstN && cpuReq) begin
        if (expQ.size() == 0) chk(0, "R5", "unexpected grant", cpuGroup, 63);
        else begin
          e = expQ.pop_front();
          chk(cpuGroup == 6'(e), "R5", "grant order", cpuGroup, e);
        end
        lastAck = cpuGroup;
        cpuAck = 1;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++; nCmp++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk(cpuReq == 0, "R1", "cpuReq at reset", cpuReq, 0);
    rd(0, d);  chk(d == 0, "R1", "enable word 0", d, 0);
    rd(4, d);  chk(d == 0, "R1", "pending word 0", d, 0);
    rd(32, d); chk(d == 7, "R1", "class 0 level", d, 7);
    rd(8, d);  chk(d == 0, "R1", "pin modes", d, 0);

    cpuMask = 7;
    wr(0, 32'hFFFF_FF7F);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk(d == 32'hF, "R10", "enable word 1 implemented bits", d, 32'hF);

    // R2 / R6: latch and exact latency (class 1 = groups 3..5)
    wr(32 + 1, 2);
    @(negedge clk); irqIn[4] = 1;
    @(negedge clk); irqIn[4] = 0;
    chk(cpuReq == 0, "R6", "no request one edge after sampling", cpuReq, 0);
    @(negedge clk);
    chk(cpuReq == 1, "R6", "request two edges after sampling", cpuReq, 1);
    chk(cpuGroup == 4, "R6", "group number", cpuGroup, 4);
    rd(4, d); chk(d[4] == 1, "R2", "pending bit 4 set", d[4], 1);
    expectGrp(4); drain();
    rd(4, d); chk(d[4] == 0, "R7", "pending cleared by ack", d[4], 0);

    // R3 disabled group still pends; R2 write-one-to-clear
    wr(32 + 2, 1);
    pulse(36'(1) << 7);
    quiet("R3", "disabled group must not request");
    rd(4, d); chk(d[7] == 1, "R3", "disabled group pending", d[7], 1);
    wr(4, 32'h80);
    rd(4, d); chk(d[7] == 0, "R2", "software clear", d[7], 0);

    // R3 system group ignores enable
    wr(32 + 0, 1);
    wr(0, 32'hFFFF_FF7B);
    pulse(36'(1) << 2);
    expectGrp(2); drain();
    wr(0, 32'hFFFF_FF7F);

    // R4 strict mask compare (class 3 = groups 9..11)
    wr(32 + 3, 3);
    cpuMask = 3;
    pulse(36'(1) << 9);
    quiet("R4", "level equal to mask blocked");
    expectGrp(9);
    autoAck = 1;
    cpuMask = 4;
    drain();
    cpuMask = 7;
    pulse(36'(1) << 12);
    quiet("R4", "level 7 never requests");
    wr(4, 32'h1000);

    // R5 ordering with class tie
    wr(32 + 5, 4);
    wr(32 + 6, 2);
    pulse((36'(1) << 17) | (36'(1) << 16) | (36'(1) << 19) | (36'(1) << 5));
    expectGrp(5); expectGrp(19); expectGrp(16); expectGrp(17);
    drain();

    // R8 / R9 external pins
    wr(32 + 10, 1);
    wr(32 + 11, 1);
    wr(8, 32'hE4);
    rd(8, d); chk(d == 32'hE4, "R10", "mode readback", d, 32'hE4);
    pulse(36'(1) << 31);
    quiet("R8", "raw input of pin group ignored");
    @(negedge clk); extPin[0] = 0;
    quiet("R8", "falling edge ignored in rising mode");
    @(negedge clk); extPin[0] = 1;
    repeat (3) @(negedge clk);
    chk(cpuReq == 0, "R9", "no request before sync delay", cpuReq, 0);
    @(negedge clk);
    chk(cpuReq == 1, "R9", "request after sync delay", cpuReq, 1);
    chk(cpuGroup == 30, "R9", "pin 0 group", cpuGroup, 30);
    expectGrp(30); drain();

    @(negedge clk); extPin[1] = 0;
    expectGrp(31); drain();
    @(negedge clk); extPin[1] = 1;
    quiet("R8", "rising edge ignored in falling mode");

    @(negedge clk); extPin[2] = 0;
    expectGrp(32); drain();
    @(negedge clk); extPin[2] = 1;
    expectGrp(32); drain();

    @(negedge clk); extPin[3] = 0;
    repeat (6) @(negedge clk);
    chk(cpuReq == 1 && cpuGroup == 33, "R8", "level pin request", cpuGroup, 33);
    wr(5, 32'h2);
    rd(5, d); chk(d[1] == 1, "R9", "level pending survives clear", d[1], 1);
    @(negedge clk); extPin[3] = 1;
    quiet("R9", "level request follows pin");
    rd(5, d); chk(d[1] == 0, "R9", "level pending released", d[1], 0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule